// File: doc/BRIEF.md
# SMBus Slave Clock-Stretch and Lock-Up Guard

This block sits beside the protocol engine of an SMBus/PMBus slave and watches the two bus lines. It decides when the slave may hold the clock line low to gain time, and it limits how long that hold may last. Stretching begins only at two protocol points reported by the byte shifter: right after a START condition, or once the acknowledge bit that closes a byte has finished. The slave's busy request must be present at that point. The hold ends when the slave is no longer busy, or when a tick-counted cap is reached, whichever comes first.

A separate watchdog measures how long both lines stay low, counting whole ticks of a 1 ms timebase. The count restarts whenever either line is seen high. It is frozen while the block itself is stretching, so the slave's own hold is never taken for a stuck bus. When the low time passes its limit, the block emits a one-cycle abort that resets the protocol engine, and it leaves the bus. From then on it ignores busy requests and protocol points, and it stays off the bus until it has seen an idle bus (both lines high) followed by a fresh START. The slave never starts a transaction and drives the clock only to stretch it. The limits (25 and 35 ticks by default) sit far above the low phase of any bus clock between 10 kHz and 400 kHz, so an ordinary slow clock is never treated as a fault.

Top module: `smbus_timeout_monitor`

## Requirements
- R1: During and right after reset, `scl_hold_low`, `abort_pulse` and `bus_released` are all 0.
- R2: When `start_seen` or `ack9_done` is high and `slave_busy` is high in the same cycle, `scl_hold_low` is 1 from the next cycle. It stays 1 while `slave_busy` stays high, until the cap of R5 is reached.
- R3: A `slave_busy` that is high with neither protocol pulse present never raises `scl_hold_low`.
- R4: While stretching, `scl_hold_low` drops in the cycle after `slave_busy` is seen low.
- R5: A stretch is capped. Counting only `tick_1ms` cycles seen while `scl_hold_low` is 1, the hold drops in the cycle after the STRETCH_TICKS-th such tick (default 25), even if `slave_busy` is still high. It is not raised again until a new protocol pulse comes with busy.
- R6: The lock-up count is cleared in every cycle where `scl_in` or `sda_in` is 1. It advances by one on each tick while both lines are 0. A tick that comes while the count already equals LOCKUP_TICKS (default 35), so the (LOCKUP_TICKS+1)-th tick in a row, causes `abort_pulse` in the next cycle. Low phases shorter than this never cause an abort.
- R7: While `scl_hold_low` is 1, the lock-up count neither advances nor clears because of the block's own hold. Ticks during a stretch do not count toward the lock-up limit.
- R8: `abort_pulse` lasts exactly one cycle. In that cycle `bus_released` becomes 1 and `scl_hold_low` becomes 0.
- R9: While `bus_released` is 1, protocol pulses and `slave_busy` are ignored, so `scl_hold_low` stays 0. Lines held low produce no further abort.
- R10: `bus_released` returns to 0 in the cycle after a START, which is `sda_in` going from 1 to 0 while `scl_in` is 1. This only counts if a cycle with both lines at 1 was seen earlier during the released period. A START without that earlier idle cycle does not end the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronized clock line level |
| sda_in | input | 1 | Synchronized data line level |
| slave_busy | input | 1 | Slave asks for time before the next bit |
| start_seen | input | 1 | Pulse from the shifter: START condition just detected |
| ack9_done | input | 1 | Pulse from the shifter: acknowledge bit of a byte just completed |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| scl_hold_low | output | 1 | Request to pull the clock line low (stretch) |
| abort_pulse | output | 1 | One-cycle reset request for the protocol engine |
| bus_released | output | 1 | Block is off the bus after a lock-up abort |

## Verification
All three outputs are registered once. Every result appears in the cycle right after the input cycle that causes it: stretch start, busy release, the cap-reaching tick, the lock-up tick and the rejoining START. The bench drives inputs and samples outputs on the falling edge. It steps a behavioural reference model on each rising edge and compares all three outputs on every cycle. Directed checks count ticks through tasks that return only after the tick has been consumed, and then look at the outputs. This lets the 24th and 25th stretch ticks, and the 35th and 36th lock-up ticks, be told apart exactly.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

  typedef enum logic {
    STR_IDLE = 1'b0,
    STR_HOLD = 1'b1
  } stretch_state_t;

  function automatic logic lines_low(input bus_lines_t l);
    return !l.scl && !l.sda;
  endfunction

  function automatic logic lines_idle(input bus_lines_t l);
    return l.scl && l.sda;
  endfunction

endpackage

// File: rtl/smbto_stretch_ctrl.sv
module smbto_stretch_ctrl
  import smbto_pkg::*;
#(
  parameter int STRETCH_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic point_pulse,
  input  logic busy,
  input  logic tick,
  input  logic kill,
  output logic hold
);

  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam logic [SW-1:0] S_LAST = SW'(STRETCH_TICKS - 1);

  stretch_state_t state_q;
  logic [SW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= STR_IDLE;
      cnt_q   <= '0;
    end else if (!enable || kill) begin
      state_q <= STR_IDLE;
      cnt_q   <= '0;
    end else if (point_pulse && busy) begin
      state_q <= STR_HOLD;
      cnt_q   <= '0;
    end else if (state_q == STR_HOLD) begin
      if (!busy) begin
        state_q <= STR_IDLE;
      end else if (tick) begin
        if (cnt_q == S_LAST) state_q <= STR_IDLE;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold = (state_q == STR_HOLD);

endmodule

// File: rtl/smbto_lockup_wdog.sv
module smbto_lockup_wdog
  import smbto_pkg::*;
#(
  parameter int LOCKUP_TICKS = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  bus_lines_t lines,
  input  logic       frozen,
  input  logic       tick,
  output logic       fire
);

  localparam int LW = $clog2(LOCKUP_TICKS + 1);
  localparam logic [LW-1:0] L_LIMIT = LW'(LOCKUP_TICKS);

  logic [LW-1:0] low_cnt_q;
  logic          both_low;

  assign both_low = lines_low(lines);

  always_comb begin
    fire = active && both_low && !frozen && tick && (low_cnt_q == L_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
    end else if (!active || !both_low) begin
      low_cnt_q <= '0;
    end else if (frozen) begin
      low_cnt_q <= low_cnt_q;
    end else if (tick) begin
      low_cnt_q <= fire ? '0 : low_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/smbto_rejoin.sv
module smbto_rejoin
  import smbto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_lines_t lines,
  input  logic       fire,
  output logic       off_bus
);

  logic off_q;
  logic idle_seen_q;
  logic sda_prev_q;
  logic start_cond;

  assign start_cond = sda_prev_q && !lines.sda && lines.scl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q       <= 1'b0;
      idle_seen_q <= 1'b0;
      sda_prev_q  <= 1'b1;
    end else begin
      sda_prev_q <= lines.sda;
      if (fire) begin
        off_q       <= 1'b1;
        idle_seen_q <= 1'b0;
      end else if (off_q) begin
        if (idle_seen_q && start_cond) begin
          off_q       <= 1'b0;
          idle_seen_q <= 1'b0;
        end else if (lines_idle(lines)) begin
          idle_seen_q <= 1'b1;
        end
      end
    end
  end

  assign off_bus = off_q;

endmodule

// File: rtl/smbus_timeout_monitor.sv
module smbus_timeout_monitor
  import smbto_pkg::*;
#(
  parameter int STRETCH_TICKS = 25,
  parameter int LOCKUP_TICKS  = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic slave_busy,
  input  logic start_seen,
  input  logic ack9_done,
  input  logic tick_1ms,
  output logic scl_hold_low,
  output logic abort_pulse,
  output logic bus_released
);

  bus_lines_t lines;
  logic       hold;
  logic       fire;
  logic       off_bus;
  logic       abort_q;

  assign lines.scl = scl_in;
  assign lines.sda = sda_in;

  smbto_stretch_ctrl #(
    .STRETCH_TICKS(STRETCH_TICKS)
  ) u_stretch (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (!off_bus),
    .point_pulse(start_seen || ack9_done),
    .busy       (slave_busy),
    .tick       (tick_1ms),
    .kill       (fire),
    .hold       (hold)
  );

  smbto_lockup_wdog #(
    .LOCKUP_TICKS(LOCKUP_TICKS)
  ) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .active(!off_bus),
    .lines (lines),
    .frozen(hold),
    .tick  (tick_1ms),
    .fire  (fire)
  );

  smbto_rejoin u_rejoin (
    .clk    (clk),
    .rst_n  (rst_n),
    .lines  (lines),
    .fire   (fire),
    .off_bus(off_bus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= fire;
  end

  assign scl_hold_low = hold;
  assign abort_pulse  = abort_q;
  assign bus_released = off_bus;

endmodule

// File: rtl/smbus_timeout_monitor_chk.sv
module smbus_timeout_monitor_chk #(
  parameter int STRETCH_TICKS = 25,
  parameter int LOCKUP_TICKS  = 35
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic slave_busy,
  input logic start_seen,
  input logic ack9_done,
  input logic tick_1ms,
  input logic scl_hold_low,
  input logic abort_pulse,
  input logic bus_released
);

  int unsigned hold_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || !scl_hold_low) hold_ticks <= 0;
    else if ((start_seen || ack9_done) && slave_busy) hold_ticks <= 0;
    else if (tick_1ms) hold_ticks <= hold_ticks + 1;
  end

  assert_hold_at_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold_low) |-> $past((start_seen || ack9_done) && slave_busy));

  assert_release_on_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold_low && !slave_busy && !start_seen && !ack9_done) |=> !scl_hold_low);

  assert_stretch_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_low |-> (hold_ticks < STRETCH_TICKS));

  assert_abort_needs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(!scl_in && !sda_in && tick_1ms));

  assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  assert_abort_leaves_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (bus_released && !scl_hold_low));

  assert_no_hold_off_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_released |-> !scl_hold_low);

  assert_rejoin_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_released) |-> $past(scl_in && !sda_in));

endmodule

bind smbus_timeout_monitor smbus_timeout_monitor_chk #(
  .STRETCH_TICKS(STRETCH_TICKS),
  .LOCKUP_TICKS (LOCKUP_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_in      (scl_in),
  .sda_in      (sda_in),
  .slave_busy  (slave_busy),
  .start_seen  (start_seen),
  .ack9_done   (ack9_done),
  .tick_1ms    (tick_1ms),
  .scl_hold_low(scl_hold_low),
  .abort_pulse (abort_pulse),
  .bus_released(bus_released)
);

// File: tb/smbus_timeout_monitor_tb.sv
module smbus_timeout_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STR = 25;
  localparam int LCK = 35;
  localparam int TICK_GAP = 4;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, busy = 1'b0, st = 1'b0, ack = 1'b0, tick = 1'b0;
  logic hold, abrt, rel;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_timeout_monitor #(.STRETCH_TICKS(STR), .LOCKUP_TICKS(LCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .slave_busy(busy),
    .start_seen(st), .ack9_done(ack), .tick_1ms(tick),
    .scl_hold_low(hold), .abort_pulse(abrt), .bus_released(rel)
  );

  // behavioural reference model
  bit m_hold = 0, m_abort = 0, m_off = 0, m_idle = 0, m_psda = 1, m_fire = 0;
  int m_scnt = 0, m_lcnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_abort = 0; m_off = 0; m_idle = 0; m_psda = 1; m_scnt = 0; m_lcnt = 0;
    end else begin
      m_fire = !m_off && !scl && !sda && !m_hold && tick && (m_lcnt == LCK);
      if (m_off || scl || sda) m_lcnt = 0;
      else if (!m_hold && tick) m_lcnt = m_fire ? 0 : m_lcnt + 1;
      if (m_off || m_fire) begin
        m_hold = 0; m_scnt = 0;
      end else if ((st || ack) && busy) begin
        m_hold = 1; m_scnt = 0;
      end else if (m_hold) begin
        if (!busy) m_hold = 0;
        else if (tick) begin
          if (m_scnt == STR - 1) m_hold = 0;
          m_scnt = m_scnt + 1;
        end
      end
      if (m_fire) begin
        m_off = 1; m_idle = 0;
      end else if (m_off) begin
        if (m_idle && m_psda && !sda && scl) begin m_off = 0; m_idle = 0; end
        else if (scl && sda) m_idle = 1;
      end
      m_psda = sda;
      m_abort = m_fire;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(hold == m_hold, "R2 R4 R5 model scl_hold_low", hold, m_hold);
      check(abrt == m_abort, "R6 R8 model abort_pulse", abrt, m_abort);
      check(rel == m_off, "R9 R10 model bus_released", rel, m_off);
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      check(0, "watchdog", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      idle(TICK_GAP);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic point(input bit is_start);
    if (is_start) st = 1'b1; else ack = 1'b1;
    @(negedge clk);
    st = 1'b0; ack = 1'b0;
  endtask

  initial begin
    idle(3);
    check(!hold && !abrt && !rel, "R1 outputs in reset", {hold, abrt, rel}, 0);
    rst_n = 1'b1;
    idle(2);
    check(!hold && !abrt && !rel, "R1 outputs after reset", {hold, abrt, rel}, 0);

    // R3: busy without a protocol point
    busy = 1'b1; scl = 1'b0;
    ticks(3);
    check(!hold, "R3 busy alone no stretch", hold, 0);
    busy = 1'b0; scl = 1'b1;
    idle(2);

    // R2 / R4: stretch after ACK, released by busy dropping
    scl = 1'b0; busy = 1'b1;
    point(1'b0);
    check(hold, "R2 stretch after ack9", hold, 1);
    ticks(10);
    check(hold, "R2 stretch held while busy", hold, 1);
    busy = 1'b0;
    @(negedge clk);
    check(!hold, "R4 release after busy drops", hold, 0);
    scl = 1'b1;
    idle(2);

    // R5: cap after START, busy kept high
    sda = 1'b0; scl = 1'b1; busy = 1'b1;
    point(1'b1);
    check(hold, "R2 stretch after start", hold, 1);
    ticks(STR - 1);
    check(hold, "R5 still holding before cap", hold, 1);
    ticks(1);
    check(!hold, "R5 released at cap", hold, 0);
    ticks(4);
    check(!hold, "R5 no re-hold without new point", hold, 0);
    busy = 1'b0; sda = 1'b1;
    idle(2);

    // R6: slow clock low phases never abort
    for (int k = 0; k < 6; k++) begin
      scl = 1'b0; sda = 1'b0;
      ticks(LCK - 5);
      scl = 1'b1;
      idle(2);
    end
    check(!abrt && !rel, "R6 slow low phases no abort", rel, 0);

    // R7: lock-up frozen during own stretch
    sda = 1'b1;
    idle(1);
    scl = 1'b0; sda = 1'b0; busy = 1'b1;
    point(1'b0);
    ticks(STR);
    check(!hold, "R5 stretch capped before lockup", hold, 0);
    ticks(LCK);
    check(!abrt && !rel, "R7 ticks during stretch not counted", rel, 0);
    ticks(1);
    check(abrt && rel && !hold, "R7 R8 abort after full low window", {abrt, rel, hold}, 6);
    @(negedge clk);
    check(!abrt && rel, "R8 abort single cycle", abrt, 0);

    // R9: ignored while released
    point(1'b0);
    check(!hold, "R9 point ignored off bus", hold, 0);
    point(1'b1);
    ticks(LCK + 5);
    check(!hold && !abrt && rel, "R9 no hold no abort off bus", {hold, abrt, rel}, 1);
    busy = 1'b0;

    // R10: START without idle is not enough
    sda = 1'b1;
    @(negedge clk);
    scl = 1'b1; sda = 1'b0;
    idle(2);
    check(rel, "R10 start without idle ignored", rel, 1);
    sda = 1'b1;
    idle(3);
    sda = 1'b0;
    @(negedge clk);
    check(!rel, "R10 rejoin after idle then start", rel, 1'b0);

    // R6: exact lock-up count from fresh low
    scl = 1'b0; sda = 1'b0;
    ticks(LCK);
    check(!abrt && !rel, "R6 no abort at limit tick", abrt, 0);
    ticks(1);
    check(abrt && rel, "R6 abort after limit exceeded", abrt, 1);
    idle(3);
    scl = 1'b1; sda = 1'b1;
    idle(2);
    sda = 1'b0;
    idle(2);
    check(!rel, "R10 second rejoin", rel, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule